// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

The controller sits beside a small 8-bit core. It picks one request at a time from four groups: a reset request, a software trap, one hardware source that cannot be masked (source 0), and ten hardware sources that can be masked (sources 1 to 10). Each request line is level-sensitive and stays pending until its producer clears it. When the core acknowledges, the controller registers the 16-bit address of the vector word for the winning request. It also registers a rank number that names the winner.

Masking depends on a two-bit software level that the controller keeps as its own register. The core changes that level with one-cycle strobes: enable, disable, return-from-interrupt and pop-condition-code. The last two load a value that the core supplies. While the core is halted, a registered wake output tells it that a pending request is allowed to end halt mode. Two decoded outputs test the level for the core's conditional jumps.

Top module: `vic_prio_ctrl`

## Requirements
- R1: On an acknowledge, the winner is the pending, eligible request of lowest rank. The rank order is: reset = 0, trap = 1, source k = k + 2 (sources 0 to 10). The rank number appears on `src_id_o` one cycle after the acknowledge.
- R2: On an accepted acknowledge, `vec_o` becomes 16'hFFFE minus twice the rank one cycle later. Reset gives FFFE, trap gives FFFC, source 0 gives FFFA and source 10 gives FFE6. The value is always even.
- R3: An enable strobe sets the level to 2'b10. A disable strobe sets it to 2'b11.
- R4: When the level is 2'b11, sources 1 to 10 are not eligible, and an acknowledge with only those pending leaves `vec_o` and `src_id_o` unchanged. Reset, trap and source 0 are accepted at any level.
- R5: A return strobe or a pop strobe loads the level from `lvl_load_i`.
- R6: An accepted acknowledge sets the level to 2'b11 one cycle later. This overrides any level strobe in the same cycle.
- R7: When level strobes arrive in the same cycle, the order of precedence is return, then pop, then disable, then enable.
- R8: `wake_o` is 1 one cycle after a cycle in which `halt_i` is 1 and a halt-exit request is pending. The halt-exit requests are reset and sources 0, 1, 2, 5, 6, 9 and 10, and the level does not mask them for this purpose. The trap and sources 3, 4, 7 and 8 never raise `wake_o`, and `wake_o` is 0 when `halt_i` was 0.
- R9: `masked_o` is 1 exactly when the level is 2'b11. `open_o` is its complement.
- R10: `irq_o` is 1 one cycle after a cycle in which at least one eligible request was pending.
- R11: After a synchronous reset, the level is 2'b11, `vec_o` is FFFE, `src_id_o` is 0, and `irq_o` and `wake_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req_i | input | 1 | Reset request (rank 0) |
| trap_req_i | input | 1 | Software trap request (rank 1) |
| src_req_i | input | 11 | Hardware requests; bit 0 cannot be masked, bits 1 to 10 can |
| ack_i | input | 1 | Core takes an interrupt this cycle |
| op_en_i | input | 1 | Enable strobe (level 10) |
| op_dis_i | input | 1 | Disable strobe (level 11) |
| op_ret_i | input | 1 | Return strobe, loads `lvl_load_i` |
| op_pop_i | input | 1 | Pop strobe, loads `lvl_load_i` |
| lvl_load_i | input | 2 | Level value for return or pop |
| halt_i | input | 1 | Core is in halt mode |
| irq_o | output | 1 | An eligible request is pending (registered) |
| vec_o | output | 16 | Vector word address of the last accepted request |
| src_id_o | output | 4 | Rank of the last accepted request |
| lvl_o | output | 2 | Current software level |
| masked_o | output | 1 | Level equals 2'b11 |
| open_o | output | 1 | Level differs from 2'b11 |
| wake_o | output | 1 | Halt-exit request seen while halted (registered) |

## Verification
The assertions check these rules on every cycle:
- a reset acknowledge yields FFFE;
- the vector stays even and no lower than FFE6;
- an acknowledge with only maskable requests pending under level 11 leaves the vector unchanged;
- a non-maskable acceptance forces the level to 11;
- a lone enable or disable strobe sets its level;
- `wake_o` stays low outside halt.

Only the bench scenarios can show the following:
- the full rank sweep, with each rank's vector and number;
- the precedence among strobes that arrive together;
- the return and pop loads;
- which sources may and may not end halt mode.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned VEC_W = 16;
  localparam logic [1:0] LVL_OPEN = 2'b10;
  localparam logic [1:0] LVL_SHUT = 2'b11;

  function automatic logic [VEC_W-1:0] vec_of(input logic [VEC_W-1:0] top,
                                               input logic [VEC_W-1:0] rank);
    return top - (rank << 1);
  endfunction
endpackage

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int unsigned NRANK = 13,
  localparam int unsigned IDW = $clog2(NRANK)
) (
  input  logic [NRANK-1:0] req_i,
  output logic             hit_o,
  output logic [IDW-1:0]   rank_o
);
  always_comb begin
    hit_o  = |req_i;
    rank_o = '0;
    for (int i = NRANK - 1; i >= 0; i--) begin
      if (req_i[i]) rank_o = IDW'(i);
    end
  end
endmodule

// File: rtl/vic_level.sv
module vic_level
  import vic_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       take_i,
  input  logic       op_en_i,
  input  logic       op_dis_i,
  input  logic       op_ret_i,
  input  logic       op_pop_i,
  input  logic [1:0] load_i,
  output logic [1:0] lvl_o
);
  always_ff @(posedge clk) begin
    if (rst)           lvl_o <= LVL_SHUT;
    else if (take_i)   lvl_o <= LVL_SHUT;
    else if (op_ret_i) lvl_o <= load_i;
    else if (op_pop_i) lvl_o <= load_i;
    else if (op_dis_i) lvl_o <= LVL_SHUT;
    else if (op_en_i)  lvl_o <= LVL_OPEN;
  end
endmodule

// File: rtl/vic_wake.sv
module vic_wake #(
  parameter int unsigned NRANK = 13,
  parameter logic [NRANK-1:0] EXIT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt_i,
  input  logic [NRANK-1:0] req_i,
  output logic             wake_o
);
  always_ff @(posedge clk) begin
    if (rst) wake_o <= 1'b0;
    else     wake_o <= halt_i && (|(req_i & EXIT));
  end
endmodule

// File: rtl/vic_prio_ctrl.sv
module vic_prio_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NMASK = 10,
  parameter logic [15:0] VEC_TOP = 16'hFFFE,
  parameter logic [NMASK+2:0] HALT_EXIT = 13'h199D,
  localparam int unsigned NRANK = NMASK + 3,
  localparam int unsigned IDW = $clog2(NRANK)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rst_req_i,
  input  logic           trap_req_i,
  input  logic [NMASK:0] src_req_i,
  input  logic           ack_i,
  input  logic           op_en_i,
  input  logic           op_dis_i,
  input  logic           op_ret_i,
  input  logic           op_pop_i,
  input  logic [1:0]     lvl_load_i,
  input  logic           halt_i,
  output logic           irq_o,
  output logic [15:0]    vec_o,
  output logic [IDW-1:0] src_id_o,
  output logic [1:0]     lvl_o,
  output logic           masked_o,
  output logic           open_o,
  output logic           wake_o
);
  logic             shut;
  logic [NRANK-1:0] raw_req;
  logic [NRANK-1:0] elig_req;
  logic             hit;
  logic [IDW-1:0]   win_rank;
  logic             take;

  assign shut     = (lvl_o == LVL_SHUT);
  assign raw_req  = {src_req_i, trap_req_i, rst_req_i};
  assign elig_req = {src_req_i[NMASK:1] & {NMASK{~shut}}, src_req_i[0], trap_req_i, rst_req_i};
  assign take     = ack_i && hit;
  assign masked_o = shut;
  assign open_o   = ~shut;

  vic_arbiter #(.NRANK(NRANK)) u_arb (
    .req_i(elig_req), .hit_o(hit), .rank_o(win_rank)
  );

  vic_level u_lvl (
    .clk(clk), .rst(rst), .take_i(take),
    .op_en_i(op_en_i), .op_dis_i(op_dis_i), .op_ret_i(op_ret_i), .op_pop_i(op_pop_i),
    .load_i(lvl_load_i), .lvl_o(lvl_o)
  );

  vic_wake #(.NRANK(NRANK), .EXIT(HALT_EXIT)) u_wake (
    .clk(clk), .rst(rst), .halt_i(halt_i), .req_i(raw_req), .wake_o(wake_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_o    <= VEC_TOP;
      src_id_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      irq_o <= hit;
      if (take) begin
        vec_o    <= vec_of(VEC_TOP, VEC_W'(win_rank));
        src_id_o <= win_rank;
      end
    end
  end
endmodule

// File: rtl/vic_prio_chk.sv
module vic_prio_chk #(
  parameter int unsigned NMASK = 10
) (
  input logic           clk,
  input logic           rst,
  input logic           rst_req_i,
  input logic           trap_req_i,
  input logic [NMASK:0] src_req_i,
  input logic           ack_i,
  input logic           op_en_i,
  input logic           op_dis_i,
  input logic           op_ret_i,
  input logic           op_pop_i,
  input logic           halt_i,
  input logic [15:0]    vec_o,
  input logic [1:0]     lvl_o,
  input logic           masked_o,
  input logic           wake_o
);
  logic nm_req;
  assign nm_req = rst_req_i || trap_req_i || src_req_i[0];

  assert_reset_first_R1: assert property (@(posedge clk) disable iff (rst)
    ack_i && rst_req_i |=> vec_o == 16'hFFFE);

  assert_vec_even_R2: assert property (@(posedge clk) disable iff (rst)
    vec_o[0] == 1'b0 && vec_o >= 16'hFFE6);

  assert_en_sets_R3: assert property (@(posedge clk) disable iff (rst)
    op_en_i && !op_dis_i && !op_ret_i && !op_pop_i && !ack_i |=> lvl_o == 2'b10);

  assert_masked_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ack_i && lvl_o == 2'b11 && !nm_req |=> $stable(vec_o));

  assert_take_shuts_R6: assert property (@(posedge clk) disable iff (rst)
    ack_i && nm_req |=> lvl_o == 2'b11);

  assert_dis_masks_R9: assert property (@(posedge clk) disable iff (rst)
    op_dis_i && !op_ret_i && !op_pop_i |=> masked_o);

  assert_no_wake_run_R8: assert property (@(posedge clk) disable iff (rst)
    !halt_i |=> !wake_o);
endmodule

bind vic_prio_ctrl vic_prio_chk #(.NMASK(NMASK)) u_chk (
  .clk(clk), .rst(rst), .rst_req_i(rst_req_i), .trap_req_i(trap_req_i),
  .src_req_i(src_req_i), .ack_i(ack_i), .op_en_i(op_en_i), .op_dis_i(op_dis_i),
  .op_ret_i(op_ret_i), .op_pop_i(op_pop_i), .halt_i(halt_i), .vec_o(vec_o),
  .lvl_o(lvl_o), .masked_o(masked_o), .wake_o(wake_o)
);

// File: tb/sim_vic_prio_ctrl.sv
`timescale 1ns/1ps
module sim_vic_prio_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_req_i = 0, trap_req_i = 0, ack_i = 0;
  logic [10:0] src_req_i = '0;
  logic op_en_i = 0, op_dis_i = 0, op_ret_i = 0, op_pop_i = 0, halt_i = 0;
  logic [1:0] lvl_load_i = 2'b00;
  logic irq_o, masked_o, open_o, wake_o;
  logic [15:0] vec_o;
  logic [3:0] src_id_o;
  logic [1:0] lvl_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vic_prio_ctrl u0 (
    .clk(clk), .rst(rst), .rst_req_i(rst_req_i), .trap_req_i(trap_req_i),
    .src_req_i(src_req_i), .ack_i(ack_i), .op_en_i(op_en_i), .op_dis_i(op_dis_i),
    .op_ret_i(op_ret_i), .op_pop_i(op_pop_i), .lvl_load_i(lvl_load_i), .halt_i(halt_i),
    .irq_o(irq_o), .vec_o(vec_o), .src_id_o(src_id_o), .lvl_o(lvl_o),
    .masked_o(masked_o), .open_o(open_o), .wake_o(wake_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    rst_req_i = 0; trap_req_i = 0; src_req_i = '0; ack_i = 0;
    op_en_i = 0; op_dis_i = 0; op_ret_i = 0; op_pop_i = 0; halt_i = 0;
  endtask

  function automatic bit exit_ok(input int rank);
    return rank == 0 || rank == 2 || rank == 3 || rank == 4 || rank == 7 ||
           rank == 8 || rank == 11 || rank == 12;
  endfunction

  task automatic set_level_open();
    op_en_i = 1; step(); op_en_i = 0;
  endtask

  task automatic t_reset();
    chk(lvl_o == 2'b11, "R11 lvl", lvl_o, 3);
    chk(vec_o == 16'hFFFE, "R11 vec", vec_o, 16'hFFFE);
    chk(src_id_o == 0 && !irq_o && !wake_o, "R11 id/irq/wake",
        {src_id_o, irq_o, wake_o}, 0);
    chk(masked_o && !open_o, "R9 reset decode", {masked_o, open_o}, 2);
  endtask

  task automatic t_enable_disable();
    set_level_open();
    chk(lvl_o == 2'b10, "R3 enable", lvl_o, 2);
    chk(!masked_o && open_o, "R9 open decode", {masked_o, open_o}, 1);
    op_dis_i = 1; step(); op_dis_i = 0;
    chk(lvl_o == 2'b11, "R3 disable", lvl_o, 3);
  endtask

  task automatic t_sweep();
    for (int r = 0; r < 13; r++) begin
      rst_req_i = (r == 0);
      trap_req_i = (r <= 1);
      for (int k = 0; k < 11; k++) src_req_i[k] = (k + 2 >= r);
      set_level_open();
      ack_i = 1; step(); ack_i = 0;
      chk(src_id_o == 4'(r), "R1 rank", src_id_o, r);
      chk(vec_o == 16'(16'hFFFE - 2 * r), "R2 vector", vec_o, 16'hFFFE - 2 * r);
      chk(lvl_o == 2'b11, "R6 level after take", lvl_o, 3);
      quiet();
    end
  endtask

  task automatic t_mask();
    logic [15:0] v0;
    logic [3:0] i0;
    v0 = vec_o; i0 = src_id_o;
    src_req_i[5] = 1; ack_i = 1; step(); ack_i = 0;
    chk(vec_o == v0 && src_id_o == i0, "R4 masked ack ignored", vec_o, v0);
    step();
    chk(!irq_o, "R10 no irq when masked", irq_o, 0);
    src_req_i[0] = 1; ack_i = 1; step(); ack_i = 0; src_req_i[0] = 0;
    chk(vec_o == 16'hFFFA, "R4 source0 at level 11", vec_o, 16'hFFFA);
    trap_req_i = 1; ack_i = 1; step(); ack_i = 0; trap_req_i = 0;
    chk(vec_o == 16'hFFFC && src_id_o == 1, "R4 trap at level 11", vec_o, 16'hFFFC);
    set_level_open();
    step();
    chk(irq_o, "R10 irq when open", irq_o, 1);
    quiet();
  endtask

  task automatic t_ret_pop();
    op_ret_i = 1; lvl_load_i = 2'b01; step(); op_ret_i = 0;
    chk(lvl_o == 2'b01, "R5 return load", lvl_o, 1);
    chk(!masked_o && open_o, "R9 level 01", {masked_o, open_o}, 1);
    op_pop_i = 1; lvl_load_i = 2'b11; step(); op_pop_i = 0;
    chk(lvl_o == 2'b11, "R5 pop load", lvl_o, 3);
  endtask

  task automatic t_strobe_order();
    op_en_i = 1; op_dis_i = 1; step(); quiet();
    chk(lvl_o == 2'b11, "R7 dis over en", lvl_o, 3);
    op_ret_i = 1; op_pop_i = 1; op_dis_i = 1; lvl_load_i = 2'b00; step(); quiet();
    chk(lvl_o == 2'b00, "R7 ret over pop/dis", lvl_o, 0);
    op_pop_i = 1; op_en_i = 1; op_dis_i = 1; lvl_load_i = 2'b10; step(); quiet();
    chk(lvl_o == 2'b10, "R7 pop over dis/en", lvl_o, 2);
    src_req_i[3] = 1; ack_i = 1; op_en_i = 1; step(); quiet();
    chk(lvl_o == 2'b11 && src_id_o == 5, "R6 take over strobe", lvl_o, 3);
  endtask

  task automatic t_wake();
    halt_i = 1;
    for (int r = 0; r < 13; r++) begin
      rst_req_i = (r == 0); trap_req_i = (r == 1);
      src_req_i = '0;
      if (r >= 2) src_req_i[r-2] = 1;
      step();
      chk(wake_o == exit_ok(r), $sformatf("R8 wake rank %0d", r), wake_o, exit_ok(r));
    end
    halt_i = 0; step();
    chk(!wake_o, "R8 no wake when running", wake_o, 0);
    quiet();
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst = 0;
    step();
    t_enable_disable();
    t_sweep();
    t_mask();
    t_ret_pop();
    t_strobe_order();
    t_wake();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule